// File: doc/BRIEF.md
# Modulo-Stride Memory Self-Test Controller

This controller tests a synchronous single-port memory in a way that a write buffer or cache between it and the cells cannot hide. It takes one offset at a time, from zero up to one less than the stride. For each offset it makes three sweeps over the whole address range. The first sweep writes the supplied pattern only to the target addresses, which are the addresses whose remainder modulo the stride equals the current offset. The second sweep writes the bit-inverse of the pattern to every other address, and it can be run several times. The third sweep reads back only the target addresses and compares them with the pattern. Each sweep takes one cycle per address, even for addresses that it does not touch, so every pass covers all of memory before the next one starts.

To use it, the integrator applies a pattern word and a repeat count and then pulses `start`. The controller then drives the memory port on its own. Each miscompare produces a one-cycle report that carries the address, the expected word and the word read back. When the last offset is finished, a done flag goes high and stays high.

Top module: `modstride_bist`

## Requirements
- R1: A `start` pulse while idle captures `pattern` and `repeat_n`, and `busy` is high from the next cycle. While busy, `start`, `pattern` and `repeat_n` are ignored.
- R2: Offsets run in ascending order from 0 to STRIDE-1. Each offset begins with a mark pass. In the mark pass, cycle i drives address i, and it writes the captured pattern only when i mod STRIDE equals the offset. The port is idle on every other cycle of the pass.
- R3: After the mark pass come N fill passes, where N is the captured `repeat_n` and a value of 0 counts as 1. Each fill pass writes the bit-inverse of the pattern to every address whose remainder differs from the offset.
- R4: The check pass follows the fill passes. It issues reads (`mem_en`=1, `mem_we`=0) only to addresses whose remainder equals the offset, and it never writes.
- R5: Every pass lasts exactly DEPTH cycles and visits addresses 0 to DEPTH-1 in ascending order. This holds even when DEPTH is not a multiple of STRIDE, in which case the remainder count restarts at 0 with every pass.
- R6: Read data is taken one cycle after the read request. If it differs from the pattern, `err_valid` is high for one cycle, two cycles after the request. In that cycle `err_addr`, `err_expected` and `err_actual` carry the address, the pattern and the word that was read.
- R7: With N the effective repeat count, `done` rises STRIDE*DEPTH*(2+N)+1 cycles after the first busy cycle. At that point `busy` is low. `done` stays high until the next accepted `start`.
- R8: During and after reset, `busy`, `done`, `err_valid`, `mem_en` and `mem_we` are 0.
- R9: `mem_we` is only ever high together with `mem_en`, and the written word is always either the captured pattern or its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a test run when idle |
| pattern | input | DW | Data word for the target addresses |
| repeat_n | input | RW | Number of fill passes (0 is treated as 1) |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable (read when low) |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid one cycle after a read |
| busy | output | 1 | Test in progress |
| done | output | 1 | Last offset finished; held until next start |
| err_valid | output | 1 | One-cycle miscompare report |
| err_addr | output | AW | Failing address |
| err_expected | output | DW | Expected word |
| err_actual | output | DW | Word read back |

## Verification
The hardest case to reach from the ports is a miscompare that the stride algorithm exists to find. In that case a target cell is overwritten by a fill-pass write to a neighbouring address. A correct memory never produces it, so the bench's memory model contains a switchable write-disturb fault: a write to one address also copies its data into the address just below. A run with the fault enabled must produce exactly one report. It must come from the check pass of the offset that selects the disturbed cell, and it must carry the inverted pattern as the actual word. The bench also sweeps every repeat count, including zero, and several patterns on a depth that is not a multiple of the stride. It predicts the port activity of every single cycle arithmetically.

// File: rtl/msb_pkg.sv
// Shared types for the modulo-stride memory self-test.
// Assumes nothing beyond a standard SystemVerilog package scope.
package msb_pkg;

    // Controller phase: one idle state, three passes per offset, one drain cycle.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_MARK  = 3'd1,
        PH_FILL  = 3'd2,
        PH_CHECK = 3'd3,
        PH_DRAIN = 3'd4
    } phase_t;

endpackage

// File: rtl/msb_walker.sv
// Address walker: steps an address counter over 0..DEPTH-1, one per cycle.
// A remainder counter runs beside it, so the target test needs no divider.
// Assumes: both counters restart at zero whenever run is low and whenever a pass wraps.
module msb_walker #(
    parameter int DEPTH  = 1024,
    parameter int STRIDE = 20,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SW    = (STRIDE > 1) ? $clog2(STRIDE) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [SW-1:0] offset,
    output logic [AW-1:0] addr,
    output logic          hit,
    output logic          last
);

    localparam logic [AW-1:0] ADDR_MAX = AW'(DEPTH - 1);
    localparam logic [SW-1:0] REM_MAX  = SW'(STRIDE - 1);

    logic [AW-1:0] addr_q;
    logic [SW-1:0] rem_q;

    // Advance the address and remainder counters, restarting both at the end of a pass.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (addr_q == ADDR_MAX) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else begin
            addr_q <= addr_q + 1'b1;
            rem_q  <= (rem_q == REM_MAX) ? '0 : rem_q + 1'b1;
        end
    end

    // Flag the current address as a target and mark the final address of a pass.
    always_comb begin
        addr = addr_q;
        hit  = (rem_q == offset);
        last = (addr_q == ADDR_MAX);
    end

endmodule

// File: rtl/msb_sequencer.sv
// Phase sequencer: steps through mark, fill (repeated) and check passes for each offset,
// then drains one cycle and raises done.
// Assumes: pass_last comes from the walker and is high on the last cycle of each pass.
module msb_sequencer
    import msb_pkg::*;
#(
    parameter int STRIDE = 20,
    parameter int DW     = 32,
    parameter int RW     = 4,
    localparam int SW    = (STRIDE > 1) ? $clog2(STRIDE) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] pattern,
    input  logic [RW-1:0] repeat_n,
    input  logic          pass_last,
    output phase_t        phase,
    output logic [SW-1:0] offset,
    output logic [DW-1:0] pat_q,
    output logic          done
);

    localparam logic [SW-1:0] OFF_MAX = SW'(STRIDE - 1);

    phase_t        phase_q;
    logic [SW-1:0] off_q;
    logic [RW-1:0] rep_q;
    logic [RW-1:0] rep_tgt_q;
    logic [DW-1:0] pat_r;
    logic          done_q;

    // Move between phases, count fill passes and offsets, and capture the run settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            off_q     <= '0;
            rep_q     <= '0;
            rep_tgt_q <= RW'(1);
            pat_r     <= '0;
            done_q    <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q   <= PH_MARK;
                        off_q     <= '0;
                        rep_q     <= '0;
                        pat_r     <= pattern;
                        rep_tgt_q <= (repeat_n == '0) ? RW'(1) : repeat_n;
                        done_q    <= 1'b0;
                    end
                end
                PH_MARK: begin
                    if (pass_last) phase_q <= PH_FILL;
                end
                PH_FILL: begin
                    if (pass_last) begin
                        if ((rep_q + RW'(1)) == rep_tgt_q) begin
                            rep_q   <= '0;
                            phase_q <= PH_CHECK;
                        end else begin
                            rep_q <= rep_q + RW'(1);
                        end
                    end
                end
                PH_CHECK: begin
                    if (pass_last) begin
                        if (off_q == OFF_MAX) begin
                            phase_q <= PH_DRAIN;
                        end else begin
                            off_q   <= off_q + 1'b1;
                            phase_q <= PH_MARK;
                        end
                    end
                end
                PH_DRAIN: begin
                    phase_q <= PH_IDLE;
                    done_q  <= 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Drive the sequencer outputs from the registered state.
    always_comb begin
        phase  = phase_q;
        offset = off_q;
        pat_q  = pat_r;
        done   = done_q;
    end

endmodule

// File: rtl/msb_compare.sv
// Read comparator: remembers each read request for one cycle, compares the returned word
// with the expected word and registers a report if they differ.
// Assumes: the memory returns read data exactly one cycle after the request.
module msb_compare #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_exp,
    input  logic [DW-1:0] rdata,
    output logic          err_valid,
    output logic [AW-1:0] err_addr,
    output logic [DW-1:0] err_expected,
    output logic [DW-1:0] err_actual
);

    logic          pend_q;
    logic [AW-1:0] pend_addr_q;
    logic [DW-1:0] pend_exp_q;
    logic          ev_q;
    logic [AW-1:0] ea_q;
    logic [DW-1:0] ee_q;
    logic [DW-1:0] ed_q;
    logic          miss;

    // Detect a miscompare on a read whose data is arriving in this cycle.
    always_comb miss = pend_q && (rdata != pend_exp_q);

    // Keep the request details until the read data comes back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
            pend_exp_q  <= '0;
        end else begin
            pend_q      <= rd_req;
            pend_addr_q <= rd_addr;
            pend_exp_q  <= rd_exp;
        end
    end

    // Register the report: a one-cycle valid, with the fields captured on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= 1'b0;
            ea_q <= '0;
            ee_q <= '0;
            ed_q <= '0;
        end else begin
            ev_q <= miss;
            if (miss) begin
                ea_q <= pend_addr_q;
                ee_q <= pend_exp_q;
                ed_q <= rdata;
            end
        end
    end

    // Drive the report outputs.
    always_comb begin
        err_valid    = ev_q;
        err_addr     = ea_q;
        err_expected = ee_q;
        err_actual   = ed_q;
    end

endmodule

// File: rtl/modstride_bist.sv
// Modulo-stride memory self-test controller, top level.
// For each offset it makes a mark pass, one or more fill passes and a check pass over a
// single-port synchronous memory, and reports every miscompare.
// Assumes: the memory takes one request per cycle and returns read data one cycle later.
module modstride_bist
    import msb_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int STRIDE = 20,
    parameter int DW     = 32,
    parameter int RW     = 4,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SW    = (STRIDE > 1) ? $clog2(STRIDE) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] pattern,
    input  logic [RW-1:0] repeat_n,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          err_valid,
    output logic [AW-1:0] err_addr,
    output logic [DW-1:0] err_expected,
    output logic [DW-1:0] err_actual
);

    phase_t        phase;
    logic [SW-1:0] offset;
    logic [DW-1:0] pat_q;
    logic [AW-1:0] walk_addr;
    logic          walk_hit;
    logic          walk_last;
    logic          walk_run;
    logic          rd_req;

    // The walker runs only while one of the three passes is active.
    always_comb walk_run = (phase == PH_MARK) || (phase == PH_FILL) || (phase == PH_CHECK);

    msb_sequencer #(
        .STRIDE (STRIDE),
        .DW     (DW),
        .RW     (RW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pattern   (pattern),
        .repeat_n  (repeat_n),
        .pass_last (walk_last),
        .phase     (phase),
        .offset    (offset),
        .pat_q     (pat_q),
        .done      (done)
    );

    msb_walker #(
        .DEPTH  (DEPTH),
        .STRIDE (STRIDE)
    ) u_walk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (walk_run),
        .offset (offset),
        .addr   (walk_addr),
        .hit    (walk_hit),
        .last   (walk_last)
    );

    // Build the memory request for the current pass and address.
    always_comb begin
        mem_addr  = walk_addr;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = pat_q;
        rd_req    = 1'b0;
        case (phase)
            PH_MARK: begin
                mem_en = walk_hit;
                mem_we = walk_hit;
            end
            PH_FILL: begin
                mem_en    = !walk_hit;
                mem_we    = !walk_hit;
                mem_wdata = ~pat_q;
            end
            PH_CHECK: begin
                mem_en = walk_hit;
                rd_req = walk_hit;
            end
            default: ;
        endcase
    end

    // Busy covers the three passes and the drain cycle.
    always_comb busy = (phase != PH_IDLE);

    msb_compare #(
        .AW (AW),
        .DW (DW)
    ) u_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_req       (rd_req),
        .rd_addr      (walk_addr),
        .rd_exp       (pat_q),
        .rdata        (mem_rdata),
        .err_valid    (err_valid),
        .err_addr     (err_addr),
        .err_expected (err_expected),
        .err_actual   (err_actual)
    );

endmodule

// File: rtl/msb_props.sv
// Property checker for the modulo-stride self-test, bound into the top module.
// Assumes: it sees the top's ports plus the captured pattern, phase and walker state.
module msb_props
    import msb_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int DW    = 32,
    parameter int AW    = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          mem_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic [DW-1:0] pat_q,
    input phase_t        phase,
    input logic          walk_run,
    input logic [AW-1:0] walk_addr,
    input logic          err_valid,
    input logic [DW-1:0] err_expected,
    input logic [DW-1:0] err_actual
);

    AST_PATTERN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pat_q)) else $error("pattern changed while busy"); // R1

    AST_CHECK_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CHECK) |-> !mem_we) else $error("write during check pass"); // R4

    AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_addr <= AW'(DEPTH - 1))) else $error("address beyond depth"); // R5

    AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_run && $past(walk_run) && ($past(walk_addr) != AW'(DEPTH - 1)))
        |-> (walk_addr == AW'($past(walk_addr) + 1'b1))) else $error("address skipped"); // R5

    AST_ERR_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_expected != err_actual)) else $error("report without mismatch"); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("done while busy"); // R7

    AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en) else $error("write without enable"); // R9

    AST_WDATA_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_wdata == pat_q) || (mem_wdata == ~pat_q))) else $error("bad write data"); // R9

endmodule

bind modstride_bist msb_props #(
    .DEPTH (DEPTH),
    .DW    (DW),
    .AW    (AW)
) u_props (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .mem_en       (mem_en),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .pat_q        (pat_q),
    .phase        (phase),
    .walk_run     (walk_run),
    .walk_addr    (walk_addr),
    .err_valid    (err_valid),
    .err_expected (err_expected),
    .err_actual   (err_actual)
);

// File: tb/modstride_bist_bench.sv
// Bench: a small configuration (depth 10, stride 3) swept over patterns, every repeat
// count and a switchable write-disturb fault, with each cycle predicted arithmetically.
module modstride_bist_bench;

    localparam int D   = 10;
    localparam int S   = 3;
    localparam int DWB = 8;
    localparam int RWB = 2;
    localparam int AWB = 4;
    localparam int FA  = 4;

    logic           clk;
    logic           rst_n;
    logic           start;
    logic [DWB-1:0] pattern;
    logic [RWB-1:0] repeat_n;
    logic           mem_en;
    logic           mem_we;
    logic [AWB-1:0] mem_addr;
    logic [DWB-1:0] mem_wdata;
    logic [DWB-1:0] mem_rdata;
    logic           busy;
    logic           done;
    logic           err_valid;
    logic [AWB-1:0] err_addr;
    logic [DWB-1:0] err_expected;
    logic [DWB-1:0] err_actual;

    logic [DWB-1:0] mem [D];
    logic           fault;
    int             total;
    int             bad;

    modstride_bist #(
        .DEPTH  (D),
        .STRIDE (S),
        .DW     (DWB),
        .RW     (RWB)
    ) u_modstride_bist (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .pattern      (pattern),
        .repeat_n     (repeat_n),
        .mem_en       (mem_en),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .busy         (busy),
        .done         (done),
        .err_valid    (err_valid),
        .err_addr     (err_addr),
        .err_expected (err_expected),
        .err_actual   (err_actual)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Memory model: one-cycle read latency; with fault set, a write to FA+1 also lands in FA.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                if (int'(mem_addr) < D) mem[mem_addr] <= mem_wdata;
                if (fault && (int'(mem_addr) == FA + 1)) mem[FA] <= mem_wdata;
            end else if (int'(mem_addr) < D) begin
                mem_rdata <= mem[mem_addr];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [DWB-1:0] p, input int r, input bit f);
        int    rr;
        int    len;
        int    last;
        int    o;
        int    w;
        int    ps;
        int    a;
        int    kk;
        bit    een;
        bit    ewe;
        bit    eerr;
        logic [DWB-1:0] ewd;
        string tag;
        rr   = (r == 0) ? 1 : r;
        len  = D * (2 + rr);
        last = S * len;
        fault = f;
        @(negedge clk);
        pattern  = p;
        repeat_n = RWB'(r);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= last + 1; k++) begin
            een = 1'b0; ewe = 1'b0; ewd = p; a = 0; tag = "R7 drain";
            if (k < last) begin
                o  = k / len;
                w  = k % len;
                ps = w / D;
                a  = w % D;
                if (ps == 0) begin
                    een = ((a % S) == o); ewe = een; tag = "R2 mark";
                end else if (ps <= rr) begin
                    een = ((a % S) != o); ewe = een; ewd = ~p; tag = "R3 fill";
                end else begin
                    een = ((a % S) == o); tag = "R4 check";
                end
            end
            eerr = 1'b0;
            kk = k - 2;
            if (f && kk >= 0 && kk < last) begin
                o  = kk / len;
                w  = kk % len;
                ps = w / D;
                eerr = (ps > rr) && ((w % D) == FA) && ((FA % S) == o);
            end
            chk(busy == (k <= last), "R1 busy", 32'(busy), 32'(k <= last));
            chk(mem_en == een, tag, 32'(mem_en), 32'(een));
            if (een) begin
                chk(int'(mem_addr) == a, "R5 address", 32'(mem_addr), 32'(a));
                chk(mem_we == ewe, tag, 32'(mem_we), 32'(ewe));
                if (ewe) chk(mem_wdata == ewd, tag, 32'(mem_wdata), 32'(ewd));
            end
            chk(err_valid == eerr, "R6 err_valid", 32'(err_valid), 32'(eerr));
            if (eerr) begin
                chk(int'(err_addr) == FA, "R6 err_addr", 32'(err_addr), 32'(FA));
                chk(err_expected == p, "R6 err_expected", 32'(err_expected), 32'(p));
                chk(err_actual == ~p, "R6 err_actual", 32'(err_actual), 32'(DWB'(~p)));
            end
            chk(done == (k == last + 1), "R7 done", 32'(done), 32'(k == last + 1));
            // Inputs that must be ignored while busy (R1).
            if (k == 5) begin
                start    = 1'b1;
                pattern  = ~p;
                repeat_n = RWB'(r + 1);
            end else if (k == 6) begin
                start    = 1'b0;
                pattern  = p;
                repeat_n = RWB'(r);
            end
            @(negedge clk);
        end
        chk(done && !busy && !mem_en, "R7 done held", {29'd0, done, busy, mem_en}, 32'd4);
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R7 watchdog actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DWB-1:0] pats [4];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h55; pats[3] = 8'hA5;
        total = 0; bad = 0;
        rst_n = 1'b0; start = 1'b0; pattern = '0; repeat_n = '0; fault = 1'b0;
        repeat (3) @(negedge clk);
        // R8: reset state while reset is held.
        chk(!busy && !done && !err_valid && !mem_en && !mem_we, "R8 in reset",
            {27'd0, busy, done, err_valid, mem_en, mem_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err_valid && !mem_en && !mem_we, "R8 after reset",
            {27'd0, busy, done, err_valid, mem_en, mem_we}, 32'd0);
        for (int pi = 0; pi < 4; pi++) begin
            for (int r = 0; r < 4; r++) begin
                for (int f = 0; f < 2; f++) begin
                    run_case(pats[pi], r, f[0]);
                end
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule